// File: doc/BRIEF.md
# Three-Phase Table Sine Reference Generator

This block produces three unsigned, amplitude-scaled sinusoidal references for a carrier-comparison PWM stage. A phase index advances by one for every cycle on which `step_en` is high, so the step source (an external NCO or an oscillator-derived strobe) has to run at 1024 times the wanted output frequency. The index reads a table whose 16-bit words each hold two 8-bit unsigned samples: phase A in the upper byte and phase B, which lags A by a third of a period, in the lower byte. The table is built at elaboration from an integer sine approximation, so no file is needed.

Each stored sample is multiplied by the amplitude command `vcmd`. The product is shifted right by the sample width, so a sample at mid-scale gives half the command. Phase C is not stored. It is derived from the two scaled phases through the three-phase zero-sum identity, adjusted by a signed trim term that cancels residual offset, and clamped to the unsigned output range. All three references come out of one register stage.

Top module: `sine3_ref_gen`

## Requirements
- R1: While `rst_n` is low, all three references read 0. After reset the phase index starts at 0.
- R2: Each clock edge with `step_en` high advances the index by one, modulo 1024, so 1023 wraps to 0. An edge with `step_en` low leaves the index unchanged.
- R3: At index k the phase-A sample is S(k) = 128 + round(127·sin(2πk/1024)), within ±1 LSB, with a range of 1 to 255.
- R4: The phase-B sample at index k is S((k − 341) mod 1024), so B lags A by 341 of 1024 steps.
- R5: `ref_a` = floor(S_A·vcmd/256) and `ref_b` = floor(S_B·vcmd/256). Both are therefore 0 when `vcmd` is 0 and never exceed `vcmd`.
- R6: The references change one clock edge after the index or `vcmd` changes, and they hold while neither changes.
- R7: `ref_c` = clamp(3·floor(vcmd/2) − ref_a − ref_b + c_trim, 0, 255), where `c_trim` is a 4-bit two's-complement value and `ref_a`, `ref_b` are the values presented on the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Advance the phase index by one on this edge |
| vcmd | input | 8 | Unsigned amplitude command |
| c_trim | input | 4 | Signed offset correction added to phase C |
| ref_a | output | 8 | Scaled phase-A reference |
| ref_b | output | 8 | Scaled phase-B reference |
| ref_c | output | 8 | Derived, trimmed and clamped phase-C reference |

## Verification
The clamp on phase C only engages near the two extremes of the C waveform, at full amplitude and with a trim that pushes past the rails. The bench reaches these conditions by counting steps to index 939, where C peaks, and to index 427, where C bottoms out. At each point it applies the extreme positive or negative trim at full command. The index wrap is reached in the same way, by carrying the step count past 1023. Table contents are compared with a real-valued sine computed in the bench, within one LSB.

// File: rtl/sine3_pkg.sv
package sine3_pkg;

    // Integer rational sine approximation over a half period, angle in
    // units where HALF steps span 0..pi; returns round(amp * sin).
    function automatic int unsigned half_sine_mag(input int unsigned k,
                                                  input int unsigned half,
                                                  input int unsigned amp);
        int unsigned pq;
        int unsigned den;
        int unsigned num;
        begin
            pq  = k * (half - k);
            den = 5 * half * half - 4 * pq;
            num = 16 * amp * pq;
            half_sine_mag = (num + den / 2) / den;
        end
    endfunction

    // Offset-binary sample for index k of a DEPTH-entry period.
    function automatic int unsigned sine_sample(input int unsigned k,
                                                input int unsigned depth,
                                                input int unsigned smp_w);
        int unsigned half;
        int unsigned mid;
        begin
            half = depth / 2;
            mid  = 1 << (smp_w - 1);
            if (k < half)
                sine_sample = mid + half_sine_mag(k, half, mid - 1);
            else
                sine_sample = mid - half_sine_mag(k - half, half, mid - 1);
        end
    endfunction

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] c;
    } ref_set_t;

endpackage

// File: rtl/sine3_idx_ctr.sv
module sine3_idx_ctr #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    output logic [ADDR_W-1:0] idx
);
    typedef struct packed {
        logic [ADDR_W-1:0] idx;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_en)
            st_d.idx = st_q.idx + ADDR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx = st_q.idx;

    // R2: one step per enabled edge, wrapping naturally
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (idx == $past(idx) + ADDR_W'(1)));

    // R2: index holds when not enabled
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(idx));

endmodule

// File: rtl/sine3_rom.sv
module sine3_rom #(
    parameter int ADDR_W = 10,
    parameter int SMP_W  = 8
) (
    input  logic [ADDR_W-1:0]  idx,
    output logic [SMP_W-1:0]   smp_a,
    output logic [SMP_W-1:0]   smp_b
);
    import sine3_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;
    localparam int LAG   = DEPTH / 3;
    localparam int WORD  = 2 * SMP_W;

    logic [WORD-1:0] tbl [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_tbl
        localparam int KB = (k + DEPTH - LAG) % DEPTH;
        assign tbl[k] = { SMP_W'(sine_sample(k,  DEPTH, SMP_W)),
                          SMP_W'(sine_sample(KB, DEPTH, SMP_W)) };
    end

    logic [WORD-1:0] word;
    assign word  = tbl[idx];
    assign smp_a = word[WORD-1:SMP_W];
    assign smp_b = word[SMP_W-1:0];

endmodule

// File: rtl/sine3_scale.sv
module sine3_scale #(
    parameter int SMP_W = 8,
    parameter int V_W   = 8
) (
    input  logic [SMP_W-1:0] smp,
    input  logic [V_W-1:0]   vcmd,
    output logic [V_W-1:0]   scaled
);
    localparam int PW = SMP_W + V_W;

    logic [PW-1:0] prod;
    assign prod   = {{V_W{1'b0}}, smp} * {{SMP_W{1'b0}}, vcmd};
    assign scaled = prod[PW-1:SMP_W];

endmodule

// File: rtl/sine3_ref_gen.sv
module sine3_ref_gen #(
    parameter int ADDR_W = 10,
    parameter int SMP_W  = 8,
    parameter int V_W    = 8,
    parameter int TRIM_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step_en,
    input  logic [V_W-1:0]           vcmd,
    input  logic signed [TRIM_W-1:0] c_trim,
    output logic [V_W-1:0]           ref_a,
    output logic [V_W-1:0]           ref_b,
    output logic [V_W-1:0]           ref_c
);
    localparam int NPH  = 2;
    localparam int VMAX = (1 << V_W) - 1;

    typedef struct packed {
        logic [V_W-1:0] a;
        logic [V_W-1:0] b;
        logic [V_W-1:0] c;
    } refs_t;

    logic [ADDR_W-1:0] idx;
    logic [SMP_W-1:0]  smp   [NPH];
    logic [V_W-1:0]    scl   [NPH];

    sine3_idx_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .idx     (idx)
    );

    sine3_rom #(.ADDR_W(ADDR_W), .SMP_W(SMP_W)) u_rom (
        .idx   (idx),
        .smp_a (smp[0]),
        .smp_b (smp[1])
    );

    for (genvar p = 0; p < NPH; p++) begin : g_scale
        sine3_scale #(.SMP_W(SMP_W), .V_W(V_W)) u_scl (
            .smp    (smp[p]),
            .vcmd   (vcmd),
            .scaled (scl[p])
        );
    end

    refs_t st_d, st_q;
    int    c_sum;

    always_comb begin
        st_d   = st_q;
        st_d.a = scl[0];
        st_d.b = scl[1];
        c_sum  = 3 * int'(vcmd >> 1) - int'(scl[0]) - int'(scl[1])
               + int'(c_trim);
        if (c_sum < 0)
            st_d.c = '0;
        else if (c_sum > VMAX)
            st_d.c = V_W'(VMAX);
        else
            st_d.c = V_W'(c_sum);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ref_a = st_q.a;
    assign ref_b = st_q.b;
    assign ref_c = st_q.c;

    // Cycles since reset, saturating; used only to qualify assertions.
    logic [1:0] age_d, age_q;
    always_comb age_d = (age_q == 2'd3) ? age_q : age_q + 2'd1;
    always_ff @(posedge clk) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    // R5: scaled phases never exceed the command that produced them
    p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_a <= $past(vcmd)) && (ref_b <= $past(vcmd)));

    // R5: zero amplitude gives zero on the stored phases
    p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vcmd == '0) |=> (ref_a == '0) && (ref_b == '0));

    // R6: outputs hold while index and inputs hold
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && !$past(step_en) && $stable(vcmd) && $stable(c_trim))
        |=> $stable(ref_a) && $stable(ref_b) && $stable(ref_c));

endmodule

// File: tb/tb_sine3_ref_gen.sv
module tb_sine3_ref_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_en = 1'b0;
    logic [7:0] vcmd = 8'd0;
    logic signed [3:0] c_trim = 4'sd0;
    logic [7:0] ref_a, ref_b, ref_c;

    int n_tests = 0;
    int n_fail  = 0;
    int idx     = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    sine3_ref_gen dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .vcmd(vcmd),
        .c_trim(c_trim), .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c)
    );

    localparam int NV = 6;
    localparam int V_STEPS [NV] = '{0, 256, 85, 171, 256, 300};
    localparam int V_AMP   [NV] = '{255, 255, 200, 128, 64, 17};
    localparam int V_TRIM  [NV] = '{0, 0, 2, -3, 5, -1};

    function automatic int exp_smp(input int k);
        real r;
        r = 128.0 + 127.0 * $sin(2.0 * 3.14159265358979 * real'(k) / 1024.0);
        return $rtoi(r + 0.5);
    endfunction

    function automatic int clamp8(input int x);
        if (x < 0) return 0;
        if (x > 255) return 255;
        return x;
    endfunction

    task automatic check(input string req, input int act, input int exp, input int tol);
        n_tests++;
        if (act - exp > tol || exp - act > tol) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic advance(input int n);
        if (n > 0) begin
            @(negedge clk) step_en = 1'b1;
            repeat (n) @(negedge clk);
            step_en = 1'b0;
            idx = (idx + n) % 1024;
        end
    endtask

    task automatic check_all(input int v, input int t);
        int ea, eb;
        ea = (exp_smp(idx) * v) / 256;
        eb = (exp_smp((idx + 1024 - 341) % 1024) * v) / 256;
        check("R3/R5 phase A", int'(ref_a), ea, 1);
        check("R4/R5 phase B", int'(ref_b), eb, 1);
        check("R7 phase C", int'(ref_c),
              clamp8(3 * (v / 2) - int'(ref_a) - int'(ref_b) + t), 0);
    endtask

    task automatic settle_and_check(input int v, input int t);
        @(negedge clk) begin vcmd = 8'(v); c_trim = 4'(t); end
        repeat (2) @(negedge clk);
        check_all(v, t);
    endtask

    initial begin
        // R1: reset state
        vcmd = 8'd255;
        repeat (3) @(negedge clk);
        check("R1 ref_a in reset", int'(ref_a), 0, 0);
        check("R1 ref_c in reset", int'(ref_c), 0, 0);
        rst_n = 1'b1;

        // Vector walk; last entry crosses the wrap (R2)
        for (int i = 0; i < NV; i++) begin
            advance(V_STEPS[i]);
            settle_and_check(V_AMP[i], V_TRIM[i]);
        end

        // R6: hold while idle
        begin
            logic [7:0] ha, hb, hc;
            ha = ref_a; hb = ref_b; hc = ref_c;
            repeat (5) @(negedge clk);
            check("R6 hold a", int'(ref_a), int'(ha), 0);
            check("R2/R6 idle keeps index b", int'(ref_b), int'(hb), 0);
            check("R6 hold c", int'(ref_c), int'(hc), 0);
        end

        // R6: one-cycle latency on an amplitude change
        @(negedge clk) vcmd = 8'd250;
        check("R6 not yet updated", int'(ref_a), (exp_smp(idx) * 17) / 256, 1);
        @(negedge clk);
        check("R6 updated after one edge", int'(ref_a), (exp_smp(idx) * 250) / 256, 1);

        // R5: zero amplitude
        settle_and_check(0, 0);
        check("R5 zero a", int'(ref_a), 0, 0);

        // R7: C peak with positive trim clamps high (index 939)
        advance(939 - idx);
        settle_and_check(255, 7);
        check("R7 clamp high", int'(ref_c), 255, 0);

        // R2: wrap to index 0
        advance(85);
        settle_and_check(255, 0);
        check("R2 wrap index 0", int'(ref_a), 127, 1);

        // R7: C trough with negative trim clamps low (index 427)
        advance(427);
        settle_and_check(255, -8);
        check("R7 clamp low", int'(ref_c), 0, 0);

        // R1: mid-run reset restarts the index
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears b", int'(ref_b), 0, 0);
        rst_n = 1'b1;
        idx = 0;
        settle_and_check(255, 0);
        check("R1 index restarts at 0", int'(ref_a), 127, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule